// File: doc/BRIEF.md
# Serial-In Latched Parallel Driver Controller

This block is the digital control core of a 32-channel output driver. Serial data is clocked into a shift register on the falling edge of the shift clock. A cascade output carries the final register stage onward, so several blocks can be chained on one serial line. An output latch captures the register contents under a latch-enable input. While that input is high the latch is transparent, and once it is low the latch holds. Two static-level inputs, blanking and polarity, then turn the latched pattern into one on/off control per channel. They can force all channels on, force all channels off, invert the pattern or pass it straight through.

A strap input selects the direction in which data walks through the channels. The bench changes it only while reset is held. An active-low asynchronous reset empties both the shift register and the latch. In this description, stage k+1 of the shift register, latch bit k and output `chanOn[k]` all belong to the same channel k.

Top module: `serial_latch_driver`

## Requirements
- R1: With `dirRev` = 0, each falling edge of `shiftClk` loads `serIn` into stage 1 (channel 0), and stage k+1 takes the old value of stage k.
- R2: With `dirRev` = 1, each falling edge loads `serIn` into stage 32 (channel 31), and stage k takes the old value of stage k+1.
- R3: `serOut` always equals the final stage in the current direction: stage 32 when `dirRev` = 0, stage 1 when `dirRev` = 1.
- R4: While `latchEn` is 1, the latch follows the shift register, including changes made by falling clock edges in that interval.
- R5: While `latchEn` is 0, the latch keeps the value it held when `latchEn` fell, whatever shifting takes place.
- R6: `blank` = 0 and `polarity` = 0 drive every bit of `chanOn` to 1, whatever the latch holds.
- R7: `blank` = 0 and `polarity` = 1 drive every bit of `chanOn` to 0, whatever the latch holds.
- R8: `blank` = 1 and `polarity` = 0 make `chanOn[k]` the inverse of latch bit k.
- R9: `blank` = 1 and `polarity` = 1 make `chanOn[k]` equal to latch bit k, where 1 means the channel is on.
- R10: `blank` and `polarity` act combinationally on `chanOn` only. They change neither the shift register nor the latch.
- R11: `rstN` = 0 clears the shift register and the latch at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shiftClk | input | 1 | Shift clock; data moves on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Serial data input |
| latchEn | input | 1 | Latch enable; transparent while high |
| blank | input | 1 | Blanking control (0 forces all channels) |
| polarity | input | 1 | Polarity control |
| dirRev | input | 1 | Direction strap: 0 forward, 1 reverse |
| serOut | output | 1 | Cascade output from the final stage |
| chanOn | output | 32 | Per-channel on/off controls |

## Verification
Two functions can act in the same cycle: a falling clock edge that shifts the register, and a transparent latch that passes the new contents straight to the channels. The bench provokes this by holding `latchEn` high across a run of shifts. After each edge it judges `chanOn` and `serOut` against a register model that is kept from the requirements. A second overlap is a change of blanking or polarity while the latch holds a pattern. The bench sweeps all four blanking and polarity codes over several loaded patterns. After each sweep it returns to pass-through mode and checks that the latch is unchanged.

// File: rtl/sld_pkg.sv
`timescale 1ns/1ps
package sld_pkg;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic forceOn;
    logic forceOff;
    logic invert;
    logic revDir;
  } drvStrobes_t;

endpackage

// File: rtl/sld_ctrl.sv
`timescale 1ns/1ps
module sld_ctrl
  import sld_pkg::*;
(
  input  logic        blank,
  input  logic        polarity,
  input  logic        dirRev,
  output drvStrobes_t strobes
);

  always_comb begin
    strobes.forceOn  = 1'b0;
    strobes.forceOff = 1'b0;
    strobes.invert   = 1'b0;
    strobes.revDir   = dirRev;
    unique case ({blank, polarity})
      2'b00:   strobes.forceOn  = 1'b1;
      2'b01:   strobes.forceOff = 1'b1;
      2'b10:   strobes.invert   = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/sld_datapath.sv
`timescale 1ns/1ps
module sld_datapath
  import sld_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              shiftClk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              latchEn,
  input  drvStrobes_t       strobes,
  output logic              serOut,
  output logic [NUM_CH-1:0] chanOn,
  output logic [NUM_CH-1:0] srQ,
  output logic [NUM_CH-1:0] latQ
);

  localparam int LAST = NUM_CH - 1;

  logic [NUM_CH-1:0] srNext;

  // Next value of each stage depends on the direction strap
  for (genvar i = 0; i < NUM_CH; i++) begin : g_stage
    logic fromLow;
    logic fromHigh;
    if (i == 0) begin : g_first
      assign fromLow = serIn;
    end else begin : g_midLow
      assign fromLow = srQ[i-1];
    end
    if (i == LAST) begin : g_last
      assign fromHigh = serIn;
    end else begin : g_midHigh
      assign fromHigh = srQ[i+1];
    end
    assign srNext[i] = strobes.revDir ? fromHigh : fromLow;
  end

  always_ff @(negedge shiftClk or negedge rstN) begin
    if (!rstN) srQ <= '0;
    else       srQ <= srNext;
  end

  // Level-sensitive output latch
  always_latch begin
    if (!rstN)        latQ <= '0;
    else if (latchEn) latQ <= srQ;
  end

  assign serOut = strobes.revDir ? srQ[0] : srQ[LAST];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    always_comb begin
      if (strobes.forceOn)       chanOn[k] = 1'b1;
      else if (strobes.forceOff) chanOn[k] = 1'b0;
      else if (strobes.invert)   chanOn[k] = ~latQ[k];
      else                       chanOn[k] = latQ[k];
    end
  end

endmodule

// File: rtl/serial_latch_driver.sv
`timescale 1ns/1ps
module serial_latch_driver
  import sld_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              shiftClk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              latchEn,
  input  logic              blank,
  input  logic              polarity,
  input  logic              dirRev,
  output logic              serOut,
  output logic [NUM_CH-1:0] chanOn
);

  drvStrobes_t       strobes;
  logic [NUM_CH-1:0] srQ;
  logic [NUM_CH-1:0] latQ;

  sld_ctrl u_ctrl (
    .blank    (blank),
    .polarity (polarity),
    .dirRev   (dirRev),
    .strobes  (strobes)
  );

  sld_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .shiftClk (shiftClk),
    .rstN     (rstN),
    .serIn    (serIn),
    .latchEn  (latchEn),
    .strobes  (strobes),
    .serOut   (serOut),
    .chanOn   (chanOn),
    .srQ      (srQ),
    .latQ     (latQ)
  );

endmodule

// File: rtl/sld_checker.sv
`timescale 1ns/1ps
module sld_checker #(
  parameter int NUM_CH = 32
) (
  input logic              shiftClk,
  input logic              rstN,
  input logic              serIn,
  input logic              latchEn,
  input logic              blank,
  input logic              polarity,
  input logic              dirRev,
  input logic              serOut,
  input logic [NUM_CH-1:0] chanOn,
  input logic [NUM_CH-1:0] srQ,
  input logic [NUM_CH-1:0] latQ
);

  // R1
  fwd_entry_chk: assert property (@(negedge shiftClk) disable iff (!rstN)
    !dirRev |=> srQ[0] == $past(serIn));

  // R2
  rev_entry_chk: assert property (@(negedge shiftClk) disable iff (!rstN)
    dirRev |=> srQ[NUM_CH-1] == $past(serIn));

  // R3
  fwd_cascade_chk: assert property (@(negedge shiftClk) disable iff (!rstN)
    !dirRev |=> serOut == $past(srQ[NUM_CH-2]));

  // R3
  rev_cascade_chk: assert property (@(negedge shiftClk) disable iff (!rstN)
    dirRev |=> serOut == $past(srQ[1]));

  // R4
  transparent_chk: assert property (@(posedge shiftClk) disable iff (!rstN)
    latchEn |-> latQ == srQ);

  // R6
  all_on_chk: assert property (@(posedge shiftClk) disable iff (!rstN)
    (!blank && !polarity) |-> chanOn == '1);

  // R7
  all_off_chk: assert property (@(posedge shiftClk) disable iff (!rstN)
    (!blank && polarity) |-> chanOn == '0);

  // R8
  invert_chk: assert property (@(posedge shiftClk) disable iff (!rstN)
    (blank && !polarity) |-> chanOn == ~latQ);

  // R11
  reset_clear_chk: assert property (@(posedge shiftClk)
    !rstN |-> (srQ == '0 && latQ == '0));

endmodule

bind serial_latch_driver sld_checker #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_serial_latch_driver.sv
`timescale 1ns/100ps
module sim_serial_latch_driver;

  localparam int NCH = 32;

  logic           shiftClk = 1'b1;
  logic           rstN = 1'b0;
  logic           serIn = 1'b0;
  logic           latchEn = 1'b0;
  logic           blank = 1'b1;
  logic           polarity = 1'b1;
  logic           dirRev = 1'b0;
  logic           serOut;
  logic [NCH-1:0] chanOn;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  logic [NCH-1:0] mSr;
  logic [NCH-1:0] mLat;

  serial_latch_driver #(.NUM_CH(NCH)) u0 (
    .shiftClk (shiftClk),
    .rstN     (rstN),
    .serIn    (serIn),
    .latchEn  (latchEn),
    .blank    (blank),
    .polarity (polarity),
    .dirRev   (dirRev),
    .serOut   (serOut),
    .chanOn   (chanOn)
  );

  always #2 shiftClk = ~shiftClk;

  // Reference model kept from the requirements (R1, R2, R4, R5, R11)
  always @(negedge shiftClk or negedge rstN) begin
    if (!rstN)       mSr = '0;
    else if (dirRev) mSr = {serIn, mSr[NCH-1:1]};
    else             mSr = {mSr[NCH-2:0], serIn};
  end

  always @* begin
    if (!rstN)        mLat = '0;
    else if (latchEn) mLat = mSr;
  end

  function automatic logic [NCH-1:0] expOut(input logic b, input logic p,
                                            input logic [NCH-1:0] l);
    case ({b, p})
      2'b00:   return '1;
      2'b01:   return '0;
      2'b10:   return ~l;
      default: return l;
    endcase
  endfunction

  function automatic logic expSer();
    return dirRev ? mSr[0] : mSr[NCH-1];
  endfunction

  task automatic chk(input string req, input logic [NCH-1:0] act,
                     input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b, input string req);
    @(posedge shiftClk);
    serIn = b;
    @(negedge shiftClk);
    #1;
    chk(req, {31'd0, serOut}, {31'd0, expSer()});
  endtask

  task automatic pulseLatch(input string req);
    @(posedge shiftClk);
    #0.5 latchEn = 1'b1;
    #0.5 chk(req, chanOn, expOut(blank, polarity, mSr));
    latchEn = 1'b0;
    #0.5;
  endtask

  task automatic loadPattern(input logic [NCH-1:0] pat, input string req);
    for (int i = NCH - 1; i >= 0; i--) shiftBit(dirRev ? pat[NCH-1-i] : pat[i], req);
  endtask

  initial begin
    logic [NCH-1:0] pats [6];
    pats[0] = 32'hA5C3_1E96;
    pats[1] = 32'h0000_0001;
    pats[2] = 32'h8000_0000;
    pats[3] = 32'hFFFF_FFFF;
    pats[4] = 32'h0000_0000;
    pats[5] = 32'h5A5A_F00F;

    // R11: reset state
    repeat (3) @(posedge shiftClk);
    #1;
    chk("R11 reset chanOn", chanOn, '0);
    chk("R11 reset serOut", {31'd0, serOut}, '0);
    @(posedge shiftClk);
    rstN = 1'b1;

    // R1/R3 forward fill, R5 latch closed
    loadPattern(pats[0], "R1 R3 forward serOut");
    chk("R1 forward fill order", mSr, pats[0]);
    chk("R5 latch closed during fill", chanOn, '0);
    pulseLatch("R4 latch pulse forward");
    chk("R1 channel mapping forward", chanOn, pats[0]);
    for (int i = 0; i < 8; i++) shiftBit(i[0], "R3 forward after latch");
    #0.5 chk("R5 hold after shifting", chanOn, pats[0]);

    // R6-R10 sweep of modes over patterns
    for (int p = 0; p < 6; p++) begin
      loadPattern(pats[p], "R3 forward serOut sweep");
      pulseLatch("R4 load for sweep");
      for (int c = 0; c < 4; c++) begin
        @(negedge shiftClk);
        #0.5;
        {blank, polarity} = c[1:0];
        #0.2;
        case (c)
          0: chk("R6 all on", chanOn, expOut(1'b0, 1'b0, pats[p]));
          1: chk("R7 all off", chanOn, expOut(1'b0, 1'b1, pats[p]));
          2: chk("R8 invert", chanOn, expOut(1'b1, 1'b0, pats[p]));
          default: chk("R9 direct", chanOn, pats[p]);
        endcase
      end
      {blank, polarity} = 2'b11;
      #0.2 chk("R10 latch untouched by modes", chanOn, pats[p]);
      chk("R10 serOut untouched by modes", {31'd0, serOut}, {31'd0, expSer()});
    end

    // R4: transparent latch while shifting (same-cycle overlap)
    @(posedge shiftClk);
    latchEn = 1'b1;
    for (int i = 0; i < 40; i++) begin
      shiftBit(((i * 7) % 3) == 0, "R3 transparent serOut");
      chk("R4 transparent follow", chanOn, mSr);
    end
    @(posedge shiftClk);
    latchEn = 1'b0;
    #0.5;
    begin
      logic [NCH-1:0] held;
      held = mSr;
      for (int i = 0; i < 5; i++) shiftBit(1'b1, "R3 after close");
      chk("R5 hold after transparent", chanOn, held);
    end

    // R2: reverse direction
    @(posedge shiftClk);
    rstN = 1'b0;
    dirRev = 1'b1;
    #0.5 chk("R11 reset before reverse", chanOn, '0);
    @(posedge shiftClk);
    rstN = 1'b1;
    loadPattern(pats[5], "R2 R3 reverse serOut");
    chk("R2 reverse fill order", mSr, pats[5]);
    pulseLatch("R2 latch pulse reverse");
    chk("R2 channel mapping reverse", chanOn, pats[5]);
    for (int i = 0; i < 6; i++) shiftBit(i[1], "R2 reverse cascade");

    // R11: asynchronous reset between edges
    @(posedge shiftClk);
    #0.5 rstN = 1'b0;
    #0.5;
    chk("R11 async clear chanOn", chanOn, '0);
    chk("R11 async clear serOut", {31'd0, serOut}, '0);
    @(posedge shiftClk);
    rstN = 1'b1;
    #1;
    chk("R11 stays clear", chanOn, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule